// File: doc/BRIEF.md
# Double-Buffered Output Code Bank with Latch Control

This block holds the output codes for a bank of 20 converter channels. Each channel keeps two 10-bit registers. A storage register receives new codes from the bus front end. An active register drives the converter. A bus front end hands over a decoded transfer in one cycle: a pointer byte and a 16-bit data word. The top three pointer bits select a command, and the low five bits select a channel.

The active registers change in one of three ways. With the latch pin low they track storage, so each write reaches the output straight away. When the pin falls, the whole bank loads from storage in one step. With the pin held high, a write that carries the software latch pattern in its top two data bits loads the whole bank once that word has been stored. Reset commands, the general-call reset and the chip reset restore default codes into both registers at once, whatever the latch pin is doing. The default code for a channel is its non-volatile preset when the preset is marked programmed, and mid-scale otherwise.

Top module: `dac_latch_bank`

## Requirements
- R1: While `rst_n` is low, at each clock edge every channel loads its default code into both its storage and its active register.
- R2: A transfer whose pointer bits 7:5 are neither 100 nor 010 writes data bits 9:0 into the storage register of the channel numbered by pointer bits 4:0. Data bits 13:10 have no effect.
- R3: With `latch_n` low, a write reaches that channel's active code at the same clock edge that updates its storage register.
- R4: With `latch_n` high, writes leave every active code unchanged, unless the write sets the software latch pattern.
- R5: On the first clock edge where `latch_n` is sampled low after being sampled high, every active register loads its storage value.
- R6: With `latch_n` high, a write with data bit 15 = 1 and bit 14 = 0 stores its code and then loads all active registers from storage, including the word just written. The patterns 11, 01 and 00 do not latch.
- R7: Pointer bits 7:5 = 100 load defaults into the storage and active registers of all channels, whatever the state of `latch_n`.
- R8: Pointer bits 7:5 = 010 load the default into both registers of the addressed channel only, whatever the state of `latch_n`.
- R9: A write or single-channel reset that names a channel number of 20 or above changes no register.
- R10: A `gc_reset` pulse loads defaults into both registers of all channels, whatever the state of `latch_n`.
- R11: The default code of channel i is `preset_codes[i*10 +: 10]` when `preset_valid` is 1, and 512 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset that loads defaults |
| gc_reset | input | 1 | One-cycle general-call reset pulse |
| latch_n | input | 1 | Latch pin: low means transparent, high means hold |
| wr_valid | input | 1 | Qualifies one decoded transfer |
| wr_ptr | input | 8 | Pointer: bits 7:5 are the command, bits 4:0 the channel |
| wr_data | input | 16 | Data word: bits 15:14 are the software latch, bits 9:0 the code |
| preset_valid | input | 1 | Non-volatile presets are programmed |
| preset_codes | input | 200 | Preset code per channel, channel i at bits i*10 +: 10 |
| active_codes | output | 200 | Active code per channel, channel i at bits i*10 +: 10 |

## Verification
Storage registers have no port of their own. A corrupted storage value stays hidden until the next falling edge of the latch pin or the next software latch, and then it shows on every affected active code one cycle later. The bench therefore pulses the latch pin after each group of held writes, so that it reads storage out through the active codes. A wrong active value shows one cycle after the write, reset or latch event that caused it, and the bench compares the whole bank against its own model at that cycle.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam logic [2:0] CMD_RST_ALL = 3'b100;
  localparam logic [2:0] CMD_RST_ONE = 3'b010;
  localparam int PTR_W   = 8;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 5;

  typedef enum logic [1:0] {OP_WRITE, OP_RST_ONE, OP_RST_ALL} op_e;

  function automatic op_e classify(input logic [2:0] cmd);
    if (cmd == CMD_RST_ALL)      return OP_RST_ALL;
    else if (cmd == CMD_RST_ONE) return OP_RST_ONE;
    else                         return OP_WRITE;
  endfunction

  function automatic logic is_sw_latch(input logic [DATA_W-1:0] d);
    return d[15] & ~d[14];
  endfunction
endpackage

// File: rtl/dac_ptr_decode.sv
module dac_ptr_decode
  import dac_bank_pkg::*;
#(
  parameter int N_CH = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_CH-1:0]   wr_hit,
  output logic [N_CH-1:0]   rst_one,
  output logic              rst_all,
  output logic              sw_latch
);
  op_e             op;
  logic [IDX_W-1:0] idx;
  logic            idx_ok;

  assign op     = classify(wr_ptr[7:5]);
  assign idx    = wr_ptr[IDX_W-1:0];
  assign idx_ok = (32'(idx) < 32'(N_CH));

  assign rst_all  = wr_valid && (op == OP_RST_ALL);
  assign sw_latch = wr_valid && (op == OP_WRITE) && idx_ok && is_sw_latch(wr_data);

  for (genvar i = 0; i < N_CH; i++) begin : g_hit
    assign wr_hit[i]  = wr_valid && (op == OP_WRITE)   && (idx == IDX_W'(i));
    assign rst_one[i] = wr_valid && (op == OP_RST_ONE) && (idx == IDX_W'(i));
  end

  // R9: at most one channel is selected per transfer
  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit) && $onehot0(rst_one));

  // R7: a bank-wide reset never also selects a single channel
  p_rst_all_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_all |-> (wr_hit == '0) && (rst_one == '0));
endmodule

// File: rtl/dac_ld_edge.sv
module dac_ld_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_n,
  output logic ld_fall,
  output logic ld_transparent
);
  logic ld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ld_q <= 1'b1;
    else        ld_q <= latch_n;
  end

  assign ld_fall        = ld_q & ~latch_n;
  assign ld_transparent = ~latch_n;

  // R5: a fall is seen only after the pin was sampled high
  p_fall_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |-> $past(latch_n));
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_default,
  input  logic [CODE_W-1:0] dflt,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              load_all,
  input  logic              transparent,
  output logic [CODE_W-1:0] storage_q,
  output logic [CODE_W-1:0] active_q
);
  logic [CODE_W-1:0] storage_n;
  logic              active_take;

  always_comb begin
    if (load_default)  storage_n = dflt;
    else if (wr_en)    storage_n = wr_code;
    else               storage_n = storage_q;
  end

  assign active_take = load_default | load_all | (transparent & wr_en);

  always_ff @(posedge clk) begin
    storage_q <= storage_n;
    if (active_take) active_q <= storage_n;
  end

  // R4: with no write-through, latch or default, the active code holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!transparent && !load_all && !load_default) |=> $stable(active_q));

  // R3: in transparent mode the active code tracks storage
  p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (transparent && !load_default) |=> (active_q == storage_q));

  // R2: a write lands in storage on the next edge
  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load_default) |=> (storage_q == $past(wr_code)));

  // R8: a default load reaches both registers
  p_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_default |=> (active_q == $past(dflt)) && (storage_q == $past(dflt)));
endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank
  import dac_bank_pkg::*;
#(
  parameter int N_CH   = 20,
  parameter int CODE_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   gc_reset,
  input  logic                   latch_n,
  input  logic                   wr_valid,
  input  logic [PTR_W-1:0]       wr_ptr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   preset_valid,
  input  logic [N_CH*CODE_W-1:0] preset_codes,
  output logic [N_CH*CODE_W-1:0] active_codes
);
  localparam int BANK_W = N_CH * CODE_W;
  localparam logic [CODE_W-1:0] MID_CODE = mid_code();

  function automatic logic [CODE_W-1:0] mid_code();
    return CODE_W'(1) << (CODE_W - 1);
  endfunction

  function automatic logic [CODE_W-1:0] pick_default(input logic programmed,
                                                     input logic [CODE_W-1:0] preset);
    return programmed ? preset : MID_CODE;
  endfunction

  logic [N_CH-1:0]   wr_hit, rst_one;
  logic              rst_all, sw_latch;
  logic              ld_fall, ld_transparent;
  logic              load_all, bank_default;
  logic [BANK_W-1:0] storage_flat;
  logic              unused_data_bits;

  assign unused_data_bits = ^wr_data[13:10];

  dac_ptr_decode #(.N_CH(N_CH)) i_decode (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .wr_hit(wr_hit), .rst_one(rst_one), .rst_all(rst_all), .sw_latch(sw_latch)
  );

  dac_ld_edge i_ld (
    .clk(clk), .rst_n(rst_n), .latch_n(latch_n),
    .ld_fall(ld_fall), .ld_transparent(ld_transparent)
  );

  assign load_all     = ld_fall | sw_latch;
  assign bank_default = ~rst_n | gc_reset | rst_all;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CODE_W-1:0] dflt;
    assign dflt = pick_default(preset_valid, preset_codes[i*CODE_W +: CODE_W]);

    dac_chan_reg #(.CODE_W(CODE_W)) i_chan (
      .clk(clk), .rst_n(rst_n),
      .load_default(bank_default | rst_one[i]),
      .dflt(dflt),
      .wr_en(wr_hit[i]),
      .wr_code(wr_data[CODE_W-1:0]),
      .load_all(load_all),
      .transparent(ld_transparent),
      .storage_q(storage_flat[i*CODE_W +: CODE_W]),
      .active_q(active_codes[i*CODE_W +: CODE_W])
    );
  end

  // R5: after a falling latch edge the whole bank matches storage
  p_fall_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> (active_codes == storage_flat));

  // R6: a software latch write leaves the bank equal to storage
  p_sw_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_latch |=> (active_codes == storage_flat));

  // R9: an out-of-range channel number touches nothing
  p_ignored_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (32'(wr_ptr[4:0]) >= 32'(N_CH)) && (wr_ptr[7:5] != CMD_RST_ALL)
     && !gc_reset && !ld_fall)
    |=> $stable(active_codes) && $stable(storage_flat));

  // R10: general-call reset restores the bank regardless of the latch pin
  p_gc_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (active_codes == storage_flat));
endmodule

// File: tb/test_dac_latch_bank.sv
module test_dac_latch_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 20;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n, gc_reset, latch_n, wr_valid, preset_valid;
  logic [7:0]  wr_ptr;
  logic [15:0] wr_data;
  logic [N*CW-1:0] preset_codes, active_codes;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [CW-1:0] m_st  [N];
  logic [CW-1:0] m_act [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_latch_bank i_dac_latch_bank (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .latch_n(latch_n),
    .wr_valid(wr_valid), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .preset_valid(preset_valid), .preset_codes(preset_codes),
    .active_codes(active_codes)
  );

  function automatic logic [CW-1:0] preset_of(int i);
    return CW'((i * 37 + 5) % 1024);
  endfunction

  function automatic logic [CW-1:0] dflt_of(int i);
    return preset_valid ? preset_of(i) : CW'(512);
  endfunction

  task automatic model_all_default();
    for (int i = 0; i < N; i++) begin m_st[i] = dflt_of(i); m_act[i] = dflt_of(i); end
  endtask

  task automatic model_latch_all();
    for (int i = 0; i < N; i++) m_act[i] = m_st[i];
  endtask

  task automatic check_bank(string tag);
    int bad = 0;
    n_tests++;
    for (int i = 0; i < N; i++) begin
      if (active_codes[i*CW +: CW] !== m_act[i]) begin
        if (bad == 0)
          $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, i,
                   active_codes[i*CW +: CW], m_act[i]);
        bad++;
      end
    end
    if (bad != 0) n_fail++;
  endtask

  // one transfer; model mirrors R2..R9
  task automatic xfer(input logic [7:0] p, input logic [15:0] d);
    int idx = int'(p[4:0]);
    @(negedge clk);
    wr_valid = 1'b1; wr_ptr = p; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (p[7:5] == 3'b100) model_all_default();
    else if (idx < N) begin
      if (p[7:5] == 3'b010) begin m_st[idx] = dflt_of(idx); m_act[idx] = dflt_of(idx); end
      else begin
        m_st[idx] = d[CW-1:0];
        if (!latch_n) m_act[idx] = m_st[idx];
        if (d[15:14] == 2'b10) model_latch_all();
      end
    end
  endtask

  task automatic ld_pulse();
    @(negedge clk); latch_n = 1'b0;
    @(negedge clk); model_latch_all();
    latch_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) preset_codes[i*CW +: CW] = preset_of(i);
    rst_n = 1'b0; gc_reset = 1'b0; latch_n = 1'b1; wr_valid = 1'b0;
    wr_ptr = '0; wr_data = '0; preset_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_all_default();
    @(negedge clk);
    check_bank("R1/R11 reset to mid-scale");

    // R4 held writes with junk in bits 13:10 (R2)
    for (int i = 0; i < N; i++) begin
      xfer(8'(i), {2'b00, 4'(i), CW'((i * 53 + 7) % 1024)});
      check_bank("R4 hold during write");
    end
    ld_pulse();
    check_bank("R5/R2 falling edge loads storage");

    // R3 transparent mode
    @(negedge clk); latch_n = 1'b0;
    @(negedge clk); model_latch_all();
    for (int i = 0; i < N; i++) begin
      xfer(8'(N - 1 - i), 16'h3C00 | 16'((i * 91 + 3) % 1024));
      check_bank("R3 transparent write");
    end
    @(negedge clk); latch_n = 1'b1;

    // R6 software latch patterns
    xfer(8'd3, 16'hC000 | 16'd111); check_bank("R6 pattern 11 no latch");
    xfer(8'd5, 16'h4000 | 16'd222); check_bank("R6 pattern 01 no latch");
    xfer(8'd7, 16'h8000 | 16'd333); check_bank("R6 pattern 10 latches bank");

    // R9 out-of-range channel numbers, write and single reset
    for (int k = N; k < 32; k++) begin
      xfer({3'b000, 5'(k)}, 16'h8000 | 16'd999);
      xfer({3'b010, 5'(k)}, 16'd0);
      check_bank("R9 ignored channel");
    end
    ld_pulse();
    check_bank("R9 storage untouched");

    // R8 single reset with latch high, and under transparency
    xfer(8'd9, 16'd444);
    xfer({3'b010, 5'd4}, 16'd0);
    check_bank("R8 single reset ch4");
    ld_pulse();
    check_bank("R8 other storage kept");
    @(negedge clk); latch_n = 1'b0;
    @(negedge clk); model_latch_all();
    xfer({3'b010, 5'd19}, 16'd0);
    check_bank("R8 single reset with latch low");
    @(negedge clk); latch_n = 1'b1;

    // R7 / R11 bank reset to presets
    preset_valid = 1'b1;
    for (int i = 0; i < N; i += 3) xfer(8'(i), 16'(i * 17));
    xfer({3'b100, 5'd0}, 16'd0);
    check_bank("R7/R11 reset-all to presets");
    ld_pulse();
    check_bank("R7 storage at presets");
    xfer({3'b010, 5'd11}, 16'd0);
    check_bank("R8/R11 single reset to preset");

    // R10 general-call reset with latch high
    for (int i = 0; i < N; i += 2) xfer(8'(i), 16'(1023 - i));
    @(negedge clk); gc_reset = 1'b1;
    @(negedge clk); gc_reset = 1'b0; model_all_default();
    check_bank("R10 general call reset");
    ld_pulse();
    check_bank("R10 storage at defaults");

    // R1 chip reset with mid-scale defaults, latch low
    preset_valid = 1'b0;
    xfer(8'd2, 16'd77);
    @(negedge clk); latch_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; model_all_default();
    check_bank("R1 reset while latch low");
    latch_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule